// File: doc/BRIEF.md
# Multilevel Page Table Walker

This block resolves a missed translation by walking a three-level forward page table that lives in ordinary memory. A requester hands it the virtual page number of the missing address together with the current root table address. The walker then performs three dependent reads. The first entry address is the root address plus the top index field. Each later entry address is the pointer returned by the previous read plus the next index field. Every index is scaled by the entry size before it is added.

Each table entry carries a valid flag in bit 0. Non-leaf entries give the next table's address in their upper bits. A leaf entry gives the physical page number and six attribute bits. If any entry read along the way is not valid, the walk stops at once and reports a page fault. It does not return a translation in that case.

Memory is reached through a plain request/response port with any latency, and only one read is in flight at a time. The result comes back as a single-cycle completion pulse. That pulse carries either the fault flag or the translation.

Top module: `pt_walker`

## Requirements
- R1: During and straight after reset, walk_idle is 1, and mem_req, walk_done, walk_fault, leaf_ppn and leaf_attr are all 0.
- R2: A request is accepted only in a cycle with walk_idle high. The accepted request's walk_vpn and root_base are captured, and mem_req rises in the next cycle. A walk_req raised while a walk is running has no effect on that walk's read addresses or result.
- R3: The first read address equals root_base plus 4 times walk_vpn[19:12] (virtual address bits 31:24).
- R4: The pointer taken from a valid non-leaf entry is the entry with bits 1:0 cleared. The second read goes to that pointer plus 4 times walk_vpn[11:6], and the third read goes to the next pointer plus 4 times walk_vpn[5:0]. Each read is issued in the cycle after the response to the previous one.
- R5: mem_req is a one-cycle pulse per read, and no further read is issued until mem_rvalid returns. A mem_rvalid that arrives while no read is pending is ignored: it causes no completion and no read.
- R6: An entry whose bit 0 is 0 at any level ends the walk. walk_done and walk_fault are then raised together, no further read follows, and leaf_ppn and leaf_attr stay 0.
- R7: A valid leaf raises walk_done with walk_fault low, leaf_ppn equal to entry bits 31:12, and leaf_attr equal to entry bits 6:1. In leaf_attr, bit 5 is read permission (entry bit 6), bit 4 is write permission (bit 5), bit 3 is execute permission (bit 4), bit 2 is referenced (bit 3), bit 1 is changed (bit 2) and bit 0 is cache-inhibit (bit 1).
- R8: walk_done lasts exactly one cycle. In every cycle with walk_done low, walk_fault, leaf_ppn and leaf_attr are 0.
- R9: walk_done rises in the cycle after the mem_rvalid that ends the walk, and walk_idle is already high in that cycle. A walk_req held in the completion cycle is therefore accepted, and mem_req rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_vpn | input | 20 | Virtual page number (virtual address bits 31:12) |
| root_base | input | 32 | Byte address of the first-level table |
| walk_idle | output | 1 | Walker is free to accept a request |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Entry returned by memory |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 1 | Completion is a page fault |
| leaf_ppn | output | 20 | Physical page number of the leaf |
| leaf_attr | output | 6 | Permission and status bits of the leaf |

## Verification
Two events can share one cycle: the completion pulse of one walk and the acceptance of the next request. The bench provokes this by raising walk_req in exactly the cycle in which walk_done is seen. It then expects mem_req with the new first-level address in the very next cycle, while the finished walk's result stays intact. A second overlap comes from a response strobe that arrives while the walker is idle, and from a request raised in the middle of a walk. In both cases the cycle-level model expects no completion and no stray read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int NUM_LEVELS = 3;
   localparam int LVL_W      = 2;
   localparam int ATTR_W     = 6;

   typedef logic [LVL_W-1:0] level_t;

   typedef enum logic [1:0] {
      WALK_IDLE,
      WALK_ISSUE,
      WALK_WAIT
   } walk_state_t;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel
   import ptw_pkg::*;
#(
   parameter int VPN_W       = 20,
   parameter int ADDR_W      = 32,
   parameter int IDX0_W      = 8,
   parameter int IDX1_W      = 6,
   parameter int IDX2_W      = 6,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [VPN_W-1:0]  vpn,
   input  logic [ADDR_W-1:0] table_ptr,
   input  level_t            level,
   output logic [ADDR_W-1:0] entry_addr
);
   localparam int ENT_SH = $clog2(ENTRY_BYTES);

   logic [ADDR_W-1:0] scaled [NUM_LEVELS];
   logic [ADDR_W-1:0] sel_off;

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      localparam int FW  = (g == 0) ? IDX0_W : (g == 1) ? IDX1_W : IDX2_W;
      localparam int FLO = (g == 0) ? (IDX1_W + IDX2_W) : (g == 1) ? IDX2_W : 0;
      assign scaled[g] = ADDR_W'(vpn[FLO +: FW]) << ENT_SH;
   end

   always_comb begin
      sel_off = scaled[0];
      for (int i = 1; i < NUM_LEVELS; i++) begin
         if (level == level_t'(i)) sel_off = scaled[i];
      end
   end

   assign entry_addr = table_ptr + sel_off;
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
   import ptw_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int OFS_W       = 12,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-1:0]       rdata,
   output logic                    ent_valid,
   output logic [ADDR_W-1:0]       ent_ptr,
   output logic [ADDR_W-OFS_W-1:0] ent_ppn,
   output logic [ATTR_W-1:0]       ent_attr
);
   localparam int ENT_SH = $clog2(ENTRY_BYTES);

   assign ent_valid = rdata[0];
   assign ent_ptr   = {rdata[ADDR_W-1:ENT_SH], {ENT_SH{1'b0}}};
   assign ent_ppn   = rdata[ADDR_W-1:OFS_W];
   assign ent_attr  = rdata[ATTR_W:1];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
   import ptw_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int ADDR_W = 32,
   parameter int PPN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              walk_req,
   input  logic [VPN_W-1:0]  walk_vpn,
   input  logic [ADDR_W-1:0] root_base,
   input  logic              mem_rvalid,
   input  logic              ent_valid,
   input  logic [ADDR_W-1:0] ent_ptr,
   input  logic [PPN_W-1:0]  ent_ppn,
   input  logic [ATTR_W-1:0] ent_attr,
   output logic              idle,
   output logic              mem_req,
   output logic [VPN_W-1:0]  vpn_q,
   output logic [ADDR_W-1:0] ptr_q,
   output level_t            level_q,
   output logic              done,
   output logic              fault,
   output logic [PPN_W-1:0]  ppn,
   output logic [ATTR_W-1:0] attr
);
   localparam level_t LAST_LVL = level_t'(NUM_LEVELS - 1);

   walk_state_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WALK_IDLE;
         vpn_q   <= '0;
         ptr_q   <= '0;
         level_q <= '0;
         done    <= 1'b0;
         fault   <= 1'b0;
         ppn     <= '0;
         attr    <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         ppn   <= '0;
         attr  <= '0;
         case (state_q)
            WALK_IDLE: begin
               if (walk_req) begin
                  vpn_q   <= walk_vpn;
                  ptr_q   <= root_base;
                  level_q <= '0;
                  state_q <= WALK_ISSUE;
               end
            end
            WALK_ISSUE: state_q <= WALK_WAIT;
            WALK_WAIT: begin
               if (mem_rvalid) begin
                  if (!ent_valid) begin
                     done    <= 1'b1;
                     fault   <= 1'b1;
                     state_q <= WALK_IDLE;
                  end else if (level_q == LAST_LVL) begin
                     done    <= 1'b1;
                     ppn     <= ent_ppn;
                     attr    <= ent_attr;
                     state_q <= WALK_IDLE;
                  end else begin
                     ptr_q   <= ent_ptr;
                     level_q <= level_t'(level_q + 1'b1);
                     state_q <= WALK_ISSUE;
                  end
               end
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   assign idle    = (state_q == WALK_IDLE);
   assign mem_req = (state_q == WALK_ISSUE);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);
   // R8
   quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (ppn == '0 && attr == '0));
   // R5
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R5
   stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && mem_rvalid && !walk_req) |=> (!done && !mem_req));
   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && walk_req) |=> mem_req);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> idle);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int OFS_W       = 12,
   parameter int IDX0_W      = 8,
   parameter int IDX1_W      = 6,
   parameter int IDX2_W      = 6,
   parameter int ENTRY_BYTES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  walk_req,
   input  logic [VA_W-OFS_W-1:0] walk_vpn,
   input  logic [PA_W-1:0]       root_base,
   output logic                  walk_idle,
   output logic                  mem_req,
   output logic [PA_W-1:0]       mem_addr,
   input  logic                  mem_rvalid,
   input  logic [PA_W-1:0]       mem_rdata,
   output logic                  walk_done,
   output logic                  walk_fault,
   output logic [PA_W-OFS_W-1:0] leaf_ppn,
   output logic [ATTR_W-1:0]     leaf_attr
);
   localparam int VPN_W  = VA_W - OFS_W;
   localparam int PPN_W  = PA_W - OFS_W;
   localparam int ENT_SH = $clog2(ENTRY_BYTES);

   if (IDX0_W + IDX1_W + IDX2_W != VPN_W) begin : g_bad_split
      $error("index fields must cover the virtual page number");
   end
   if ((1 << ENT_SH) != ENTRY_BYTES || ENT_SH < 1) begin : g_bad_entry
      $error("entry size must be a power of two of at least two bytes");
   end
   if (OFS_W <= ATTR_W) begin : g_bad_offset
      $error("page offset too narrow to hold the attribute bits");
   end

   logic [VPN_W-1:0]  vpn_q;
   logic [PA_W-1:0]   ptr_q;
   level_t            level_q;
   logic              ent_valid;
   logic [PA_W-1:0]   ent_ptr;
   logic [PPN_W-1:0]  ent_ppn;
   logic [ATTR_W-1:0] ent_attr;

   ptw_ctrl #(.VPN_W(VPN_W), .ADDR_W(PA_W), .PPN_W(PPN_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .walk_req  (walk_req),
      .walk_vpn  (walk_vpn),
      .root_base (root_base),
      .mem_rvalid(mem_rvalid),
      .ent_valid (ent_valid),
      .ent_ptr   (ent_ptr),
      .ent_ppn   (ent_ppn),
      .ent_attr  (ent_attr),
      .idle      (walk_idle),
      .mem_req   (mem_req),
      .vpn_q     (vpn_q),
      .ptr_q     (ptr_q),
      .level_q   (level_q),
      .done      (walk_done),
      .fault     (walk_fault),
      .ppn       (leaf_ppn),
      .attr      (leaf_attr)
   );

   ptw_index_sel #(
      .VPN_W(VPN_W), .ADDR_W(PA_W), .IDX0_W(IDX0_W), .IDX1_W(IDX1_W),
      .IDX2_W(IDX2_W), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_index (
      .vpn       (vpn_q),
      .table_ptr (ptr_q),
      .level     (level_q),
      .entry_addr(mem_addr)
   );

   ptw_entry_dec #(.ADDR_W(PA_W), .OFS_W(OFS_W), .ENTRY_BYTES(ENTRY_BYTES)) u_dec (
      .rdata    (mem_rdata),
      .ent_valid(ent_valid),
      .ent_ptr  (ent_ptr),
      .ent_ppn  (ent_ppn),
      .ent_attr (ent_attr)
   );
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_req = 1'b0;
   logic [19:0] walk_vpn = '0;
   logic [31:0] root_base = '0;
   logic        walk_idle, mem_req, walk_done, walk_fault;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [19:0] leaf_ppn;
   logic [5:0]  leaf_attr;

   pt_walker u_pt_walker (
      .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_vpn(walk_vpn),
      .root_base(root_base), .walk_idle(walk_idle), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .walk_done(walk_done), .walk_fault(walk_fault), .leaf_ppn(leaf_ppn),
      .leaf_attr(leaf_attr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] idx_off(logic [19:0] vpn, int lvl);
      case (lvl)
         0:       return {22'b0, vpn[19:12], 2'b00};
         1:       return {24'b0, vpn[11:6], 2'b00};
         default: return {24'b0, vpn[5:0], 2'b00};
      endcase
   endfunction

   // memory model
   logic [31:0] mem [logic [31:0]];
   int lat_cfg = 1;
   int rd_cnt = 0;
   int stray_tok = 0;
   int stray_seen = 0;
   bit pend = 0;
   int cnt = 0;
   logic [31:0] paddr = '0;

   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (stray_tok != stray_seen) begin
         stray_seen = stray_tok;
         mem_rvalid = 1'b1;
         mem_rdata  = 32'h0000_1001;
      end
      if (pend) begin
         cnt--;
         if (cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem.exists(paddr) ? mem[paddr] : 32'h0;
            pend = 0;
         end
      end
      if (mem_req) begin
         pend  = 1;
         paddr = mem_addr;
         cnt   = lat_cfg;
         rd_cnt++;
      end
   end

   // cycle-level reference model
   bit          m_busy = 0;
   int          m_lvl = 0;
   logic [19:0] m_vpn = '0;
   bit          e_idle = 1, e_req = 0, e_done = 0, e_fault = 0;
   logic [31:0] e_addr = '0;
   int          e_lvl = 0;
   logic [19:0] e_ppn = '0;
   logic [5:0]  e_attr = '0;

   always @(posedge clk) begin
      e_req = 0; e_done = 0; e_fault = 0; e_ppn = '0; e_attr = '0;
      if (!rst_n) begin
         m_busy = 0;
      end else if (!m_busy) begin
         if (walk_req) begin
            m_busy = 1; m_lvl = 0; m_vpn = walk_vpn;
            e_addr = root_base + idx_off(walk_vpn, 0);
            e_req = 1; e_lvl = 0;
         end
      end else if (mem_rvalid) begin
         if (!mem_rdata[0]) begin
            e_done = 1; e_fault = 1; m_busy = 0;
         end else if (m_lvl == 2) begin
            e_done = 1; e_ppn = mem_rdata[31:12]; e_attr = mem_rdata[6:1]; m_busy = 0;
         end else begin
            m_lvl++;
            e_addr = (mem_rdata & ~32'h3) + idx_off(m_vpn, m_lvl);
            e_req = 1; e_lvl = m_lvl;
         end
      end
      e_idle = !m_busy;
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(walk_idle == e_idle, "R2", "idle", 32'(walk_idle), 32'(e_idle));
         chk(mem_req == e_req, "R5", "mem_req", 32'(mem_req), 32'(e_req));
         if (e_req)
            chk(mem_addr == e_addr, (e_lvl == 0) ? "R3" : "R4", "mem_addr", mem_addr, e_addr);
         chk(walk_done == e_done, "R9", "done", 32'(walk_done), 32'(e_done));
         chk(walk_fault == e_fault, "R6", "fault", 32'(walk_fault), 32'(e_fault));
         chk(leaf_ppn == e_ppn, "R8", "ppn", 32'(leaf_ppn), 32'(e_ppn));
         chk(leaf_attr == e_attr, "R7", "attr", 32'(leaf_attr), 32'(e_attr));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         finished = 1;
         bad++;
         total++;
         $display("FAIL watchdog expired act=%0d exp<=%0d", cyc, 50000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic build(logic [31:0] base, logic [31:0] va, logic [31:0] t1,
                        logic [31:0] t2, logic [31:0] leaf);
      logic [19:0] v;
      v = va[31:12];
      mem[base + idx_off(v, 0)] = t1 | 32'h1;
      mem[(t1 & ~32'h3) + idx_off(v, 1)] = t2 | 32'h1;
      mem[(t2 & ~32'h3) + idx_off(v, 2)] = leaf;
   endtask

   task automatic wait_done(string tag);
      int guard;
      guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!walk_done && guard < 200);
      chk(walk_done == 1'b1, tag, "done seen", 32'(walk_done), 32'h1);
   endtask

   task automatic do_walk(logic [31:0] va, logic [31:0] base, int lat, bit x_fault,
                          logic [19:0] x_ppn, logic [5:0] x_attr, int x_reads, string tag);
      int start;
      lat_cfg = lat;
      start = rd_cnt;
      @(negedge clk);
      walk_req = 1'b1; walk_vpn = va[31:12]; root_base = base;
      @(negedge clk);
      walk_req = 1'b0;
      wait_done(tag);
      chk(walk_fault == x_fault, tag, "fault", 32'(walk_fault), 32'(x_fault));
      chk(leaf_ppn == x_ppn, tag, "ppn", 32'(leaf_ppn), 32'(x_ppn));
      chk(leaf_attr == x_attr, tag, "attr", 32'(leaf_attr), 32'(x_attr));
      chk(rd_cnt - start == x_reads, tag, "reads", 32'(rd_cnt - start), 32'(x_reads));
   endtask

   localparam logic [31:0] BASE_A = 32'h0001_0000;
   localparam logic [31:0] BASE_B = 32'h0080_0000;
   localparam logic [31:0] VA0 = 32'h1234_5678;
   localparam logic [31:0] VA1 = 32'h8765_4321;
   localparam logic [31:0] VA2 = 32'h5500_0000;
   localparam logic [31:0] VA3 = 32'h12FC_0000;
   localparam logic [31:0] VA4 = 32'h1234_7000;

   initial begin
      build(BASE_A, VA0, 32'h0002_0000, 32'h0003_0000, 32'hABCD_E07F);
      build(BASE_A, VA1, 32'h0004_0002, 32'h0005_0000, 32'h1234_5055);
      build(BASE_B, VA0, 32'h0009_0000, 32'h000A_0000, 32'h7777_7003);
      mem[32'h0003_0000 + idx_off(VA4[31:12], 2)] = 32'hFFFF_FFFE;

      // R1: reset state
      repeat (2) @(negedge clk);
      chk(walk_idle == 1'b1, "R1", "idle", 32'(walk_idle), 32'h1);
      chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'h0);
      chk(walk_done == 1'b0 && walk_fault == 1'b0, "R1", "done/fault",
          {30'b0, walk_done, walk_fault}, 32'h0);
      chk(leaf_ppn == '0 && leaf_attr == '0, "R1", "result", {6'b0, leaf_attr, leaf_ppn}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R4 R7: full walks, attribute patterns and pointer masking
      do_walk(VA0, BASE_A, 1, 1'b0, 20'hABCDE, 6'h3F, 3, "R7");
      do_walk(VA1, BASE_A, 4, 1'b0, 20'h12345, 6'h2A, 3, "R4");
      do_walk(VA0, BASE_B, 7, 1'b0, 20'h77777, 6'h01, 3, "R3");

      // R6: faults at each level
      do_walk(VA2, BASE_A, 2, 1'b1, 20'h0, 6'h0, 1, "R6");
      do_walk(VA3, BASE_A, 3, 1'b1, 20'h0, 6'h0, 2, "R6");
      do_walk(VA4, BASE_A, 1, 1'b1, 20'h0, 6'h0, 3, "R6");

      // R2: request during a running walk is ignored
      fork
         do_walk(VA0, BASE_A, 5, 1'b0, 20'hABCDE, 6'h3F, 3, "R2");
         begin
            repeat (4) @(negedge clk);
            walk_req = 1'b1; walk_vpn = VA1[31:12]; root_base = BASE_B;
            @(negedge clk);
            walk_req = 1'b0;
         end
      join

      // R5: response strobe while idle is ignored
      repeat (2) @(negedge clk);
      stray_tok++;
      repeat (2) @(negedge clk);
      chk(walk_done == 1'b0, "R5", "stray done", 32'(walk_done), 32'h0);
      chk(walk_idle == 1'b1 && mem_req == 1'b0, "R5", "stray idle/req",
          {30'b0, walk_idle, mem_req}, 32'h2);

      // R9: new request accepted in the completion cycle
      lat_cfg = 2;
      @(negedge clk);
      walk_req = 1'b1; walk_vpn = VA0[31:12]; root_base = BASE_A;
      @(negedge clk);
      walk_req = 1'b0;
      wait_done("R9");
      chk(walk_idle == 1'b1, "R9", "idle at done", 32'(walk_idle), 32'h1);
      chk(leaf_ppn == 20'hABCDE, "R9", "first ppn", 32'(leaf_ppn), 32'hABCDE);
      walk_req = 1'b1; walk_vpn = VA1[31:12];
      @(negedge clk);
      walk_req = 1'b0;
      chk(mem_req == 1'b1, "R9", "back-to-back req", 32'(mem_req), 32'h1);
      chk(mem_addr == BASE_A + idx_off(VA1[31:12], 0), "R9", "back-to-back addr",
          mem_addr, BASE_A + idx_off(VA1[31:12], 0));
      wait_done("R9");
      chk(leaf_ppn == 20'h12345 && walk_fault == 1'b0, "R9", "second ppn",
          32'(leaf_ppn), 32'h12345);
      @(negedge clk);
      chk(walk_done == 1'b0 && leaf_ppn == '0, "R8", "after pulse",
          {11'b0, walk_done, leaf_ppn}, 32'h0);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule